// File: doc/BRIEF.md
# Serial Port Byte Buffers with Fill-Level Status

This block holds the two byte queues that sit between a host and an asynchronous serial port. The transmit queue accepts bytes from the host and hands them to the serializer in arrival order. The receive queue accepts bytes from the deserializer and hands them to the host. Each queue is governed by its own control register. That register carries an enable bit, a self-clearing flush bit and a 6-bit interrupt trigger level. A read-only status word packs three counts into one read: the receive fill level, the transmit fill level and the transmit free space.

Each queue is built around a three-state occupancy machine with states EMPTY, PARTIAL and FULL. Its transitions are:
- FILL: EMPTY to PARTIAL, on an accepted push.
- TOP: PARTIAL to FULL, on an accepted push that takes the last free slot.
- DRAIN: FULL to PARTIAL, on an accepted pop.
- DRY: PARTIAL to EMPTY, on an accepted pop of the last byte.
- FLUSH: any state to EMPTY, on a register write that sets the flush bit.

A push and a pop accepted in the same cycle leave the state unchanged. The enable bit gates every push and pop, but it does not clear the contents.

Register access uses a single write strobe and a 2-bit address. Reads are combinational:
- Address 0: transmit control.
- Address 1: receive control.
- Address 2: status.
- Address 3: reads as zero.

Two level-sensitive interrupt outputs compare each fill level against its trigger. The receive interrupt requests service when enough bytes have arrived. The transmit interrupt requests a refill when the queue has run low.

Top module: `serfifo_top`

## Requirements
- R1: After reset both queues are disabled and empty, every trigger level is 0, the status word reads free space 32 with both fill levels 0, both interrupts are low, tx_data and rx_rdata are 0, and tx_empty is high.
- R2: A control register (address 0 for transmit, 1 for receive) reads back enable at bit 0, the trigger level at bits 13:8, and 0 in every other bit; the flush bit 1 always reads 0. Address 3 reads 0.
- R3: The status word at address 2 has receive fill level at bits 5:0, transmit fill level at bits 13:8, transmit free-slot count (32 minus transmit fill) at bits 29:24, zeros elsewhere.
- R4: Each queue delivers bytes in push order; an accepted pop (tx_pop or rx_rd) places the byte on tx_data / rx_rdata from the next cycle until the next accepted pop.
- R5: tx_ready is high only when the transmit queue is enabled and its free-slot count is nonzero; a host write (tx_wr) to a full transmit queue is dropped, even when a pop is accepted in the same cycle.
- R6: tx_empty is high exactly when the transmit fill level is 0; tx_valid is high when the transmit queue is enabled and non-empty.
- R7: A control write with bit 1 set empties that queue at the write's clock edge, discarding any push in that same cycle; writing enable and flush together leaves the queue empty and enabled.
- R8: Writing enable 0 with flush 1 discards the contents and disables the queue; while disabled, pushes and pops are ignored and the count and data outputs do not change.
- R9: A pop from an empty queue leaves the count unchanged and the data output at its last value.
- R10: irq_rx is high exactly when the receive queue is enabled and its fill level is greater than or equal to its trigger level.
- R11: irq_tx is high exactly when the transmit queue is enabled and its fill level is less than or equal to its trigger level.
- R12: A push and a pop accepted in the same cycle on a partially filled queue leave the fill level unchanged and preserve order.
- R13: A deserializer push (rx_push) into a full receive queue is dropped, and no level ever exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 tx ctrl, 1 rx ctrl, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tx_wr | input | 1 | Host pushes a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmit queue enabled and has a free slot |
| tx_pop | input | 1 | Serializer takes a byte |
| tx_data | output | 8 | Last byte popped for the serializer |
| tx_valid | output | 1 | Transmit queue enabled and holds a byte |
| tx_empty | output | 1 | Transmit fill level is zero |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_pdata | input | 8 | Received byte |
| rx_rd | input | 1 | Host takes a received byte |
| rx_rdata | output | 8 | Last byte popped for the host |
| irq_tx | output | 1 | Transmit level at or below trigger |
| irq_rx | output | 1 | Receive level at or above trigger |

## Verification
A wrong occupancy state in either queue shows up at the ports within one cycle. A stuck FULL drops tx_ready or discards a push that the status count then lacks. A stuck EMPTY refuses a pop, so tx_data or rx_rdata fails to advance on the next cycle. A corrupted pointer appears as an out-of-order byte at the first pop that reaches the bad slot, so detection may trail the fault by up to 32 pops. A miscounted level changes the status word and can move an interrupt edge in the same cycle as the error. Comparing every output against a queue model on each clock catches each of these at its first visible cycle.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;

    // Register addresses; the host software depends on these codes.
    localparam logic [1:0] ADDR_TXCTL = 2'd0;
    localparam logic [1:0] ADDR_RXCTL = 2'd1;
    localparam logic [1:0] ADDR_STAT  = 2'd2;

    // Control field positions.
    localparam int EN_BIT    = 0;
    localparam int FLUSH_BIT = 1;
    localparam int TRIG_LSB  = 8;
    localparam int TRIG_W    = 6;

    // Status field positions.
    localparam int ST_RXLVL_LSB = 0;
    localparam int ST_TXLVL_LSB = 8;
    localparam int ST_TXFREE_LSB = 24;
    localparam int ST_FIELD_W   = 6;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_PART  = 2'd1,
        S_FULL  = 2'd2
    } fifo_state_e;

endpackage

// File: rtl/serfifo_queue.sv
module serfifo_queue
    import serfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] level
);

    fifo_state_e   state_q, state_d;
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] level_q;
    logic          push_ok, pop_ok;

    // Output process: acceptance decoded from the occupancy state.
    always_comb begin
        push_ok = en && push && !flush && (state_q != S_FULL);
        pop_ok  = en && pop  && !flush && (state_q != S_EMPTY);
    end

    // Next-state process: FILL, TOP, DRAIN, DRY and FLUSH transitions.
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = S_EMPTY;
        end else begin
            unique case (state_q)
                S_EMPTY: if (push_ok) state_d = S_PART;
                S_PART: begin
                    if (push_ok && !pop_ok && level_q == CW'(DEPTH - 1))
                        state_d = S_FULL;
                    else if (pop_ok && !push_ok && level_q == CW'(1))
                        state_d = S_EMPTY;
                end
                S_FULL: if (pop_ok) state_d = S_PART;
                default: state_d = S_EMPTY;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_q <= '0;
        end else if (flush) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_q <= '0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + AW'(1);
            if (pop_ok)  rptr_q <= rptr_q + AW'(1);
            unique case ({push_ok, pop_ok})
                2'b10:   level_q <= level_q + CW'(1);
                2'b01:   level_q <= level_q - CW'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pop_data <= '0;
        else if (pop_ok) pop_data <= mem[rptr_q];
    end

    assign level = level_q;

    // R13
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= CW'(DEPTH));

    // R5
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FULL) == (level_q == CW'(DEPTH)));

    // R6
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMPTY) == (level_q == '0));

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level_q == '0));

    // R9
    dry_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level_q == '0) |=> ($stable(pop_data) && level_q == '0));

endmodule

// File: rtl/serfifo_regs.sv
module serfifo_regs
    import serfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [CW-1:0] tx_lvl,
    input  logic [CW-1:0] rx_lvl,
    input  logic [CW-1:0] tx_free,
    output logic          tx_en,
    output logic          rx_en,
    output logic          tx_flush,
    output logic          rx_flush,
    output logic          irq_tx,
    output logic          irq_rx
);

    logic [TRIG_W-1:0] tx_trig_q, rx_trig_q;
    logic              tx_sel, rx_sel;
    logic              unused_wbits;

    assign tx_sel   = reg_wr && (reg_addr == ADDR_TXCTL);
    assign rx_sel   = reg_wr && (reg_addr == ADDR_RXCTL);
    assign tx_flush = tx_sel && reg_wdata[FLUSH_BIT];
    assign rx_flush = rx_sel && reg_wdata[FLUSH_BIT];
    assign unused_wbits = ^{reg_wdata[31:TRIG_LSB+TRIG_W], reg_wdata[TRIG_LSB-1:FLUSH_BIT+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en     <= 1'b0;
            rx_en     <= 1'b0;
            tx_trig_q <= '0;
            rx_trig_q <= '0;
        end else begin
            if (tx_sel) begin
                tx_en     <= reg_wdata[EN_BIT];
                tx_trig_q <= reg_wdata[TRIG_LSB +: TRIG_W];
            end
            if (rx_sel) begin
                rx_en     <= reg_wdata[EN_BIT];
                rx_trig_q <= reg_wdata[TRIG_LSB +: TRIG_W];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_TXCTL: begin
                reg_rdata[EN_BIT]               = tx_en;
                reg_rdata[TRIG_LSB +: TRIG_W]   = tx_trig_q;
            end
            ADDR_RXCTL: begin
                reg_rdata[EN_BIT]               = rx_en;
                reg_rdata[TRIG_LSB +: TRIG_W]   = rx_trig_q;
            end
            ADDR_STAT: begin
                reg_rdata[ST_RXLVL_LSB  +: ST_FIELD_W] = ST_FIELD_W'(rx_lvl);
                reg_rdata[ST_TXLVL_LSB  +: ST_FIELD_W] = ST_FIELD_W'(tx_lvl);
                reg_rdata[ST_TXFREE_LSB +: ST_FIELD_W] = ST_FIELD_W'(tx_free);
            end
            default: reg_rdata = '0;
        endcase
    end

    assign irq_rx = rx_en && (int'(rx_lvl) >= int'(rx_trig_q));
    assign irq_tx = tx_en && (int'(tx_lvl) <= int'(tx_trig_q));

    // R10
    rx_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_lvl == '0 && rx_trig_q != '0) |-> !irq_rx);

    // R11
    tx_irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_lvl == '0) |-> irq_tx);

endmodule

// File: rtl/serfifo_top.sv
module serfifo_top
    import serfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    output logic          tx_ready,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    output logic          tx_empty,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_pdata,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_rdata,
    output logic          irq_tx,
    output logic          irq_rx
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] tx_lvl, rx_lvl, tx_free;
    logic          tx_en, rx_en, tx_flush, rx_flush;

    assign tx_free  = CW'(DEPTH) - tx_lvl;
    assign tx_ready = tx_en && (tx_free != '0);
    assign tx_empty = (tx_lvl == '0);
    assign tx_valid = tx_en && !tx_empty;

    serfifo_regs #(.DEPTH(DEPTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .tx_lvl   (tx_lvl),
        .rx_lvl   (rx_lvl),
        .tx_free  (tx_free),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .tx_flush (tx_flush),
        .rx_flush (rx_flush),
        .irq_tx   (irq_tx),
        .irq_rx   (irq_rx)
    );

    serfifo_queue #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .flush    (tx_flush),
        .push     (tx_wr),
        .push_data(tx_wdata),
        .pop      (tx_pop),
        .pop_data (tx_data),
        .level    (tx_lvl)
    );

    serfifo_queue #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .flush    (rx_flush),
        .push     (rx_push),
        .push_data(rx_pdata),
        .pop      (rx_rd),
        .pop_data (rx_rdata),
        .level    (rx_lvl)
    );

    // R5
    tx_ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl == CW'(DEPTH)) |-> !tx_ready);

endmodule

// File: tb/tb_serfifo_top.sv
module tb_serfifo_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        tx_wr, tx_pop, rx_push, rx_rd;
    logic [7:0]  tx_wdata, rx_pdata;
    logic [7:0]  tx_data, rx_rdata;
    logic        tx_ready, tx_valid, tx_empty, irq_tx, irq_rx;

    always #2 clk = ~clk;

    serfifo_top dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_ready(tx_ready), .tx_pop(tx_pop),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_pdata(rx_pdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    // Behavioural reference model.
    bit         m_tx_en, m_rx_en;
    int         m_tx_trig, m_rx_trig;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [7:0] m_txd, m_rxd;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        logic [31:0] r = '0;
        case (a)
            2'd0: r = (32'(m_tx_trig) << 8) | 32'(m_tx_en);
            2'd1: r = (32'(m_rx_trig) << 8) | 32'(m_rx_en);
            2'd2: r = (32'(32 - txq.size()) << 24) | (32'(txq.size()) << 8) | 32'(rxq.size());
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic compare_all();
        chk((reg_addr == 2'd2) ? "R3" : "R2", reg_rdata, exp_rdata(reg_addr), "reg_rdata");
        chk("R5", 32'(tx_ready), 32'(m_tx_en && txq.size() < 32), "tx_ready");
        chk("R6", 32'(tx_empty), 32'(txq.size() == 0), "tx_empty");
        chk("R6", 32'(tx_valid), 32'(m_tx_en && txq.size() != 0), "tx_valid");
        chk("R4", 32'(tx_data), 32'(m_txd), "tx_data");
        chk("R4", 32'(rx_rdata), 32'(m_rxd), "rx_rdata");
        chk("R10", 32'(irq_rx), 32'(m_rx_en && rxq.size() >= m_rx_trig), "irq_rx");
        chk("R11", 32'(irq_tx), 32'(m_tx_en && txq.size() <= m_tx_trig), "irq_tx");
    endtask

    // Apply model for the inputs currently driven, advance one clock, compare.
    task automatic step();
        bit fl_tx = reg_wr && reg_addr == 2'd0 && reg_wdata[1];
        bit fl_rx = reg_wr && reg_addr == 2'd1 && reg_wdata[1];
        bit tpop = m_tx_en && tx_pop && txq.size() > 0;
        bit tpsh = m_tx_en && tx_wr && txq.size() < 32;
        bit rpop = m_rx_en && rx_rd && rxq.size() > 0;
        bit rpsh = m_rx_en && rx_push && rxq.size() < 32;
        if (fl_tx) txq.delete();
        else begin
            if (tpop) m_txd = txq.pop_front();
            if (tpsh) txq.push_back(tx_wdata);
        end
        if (fl_rx) rxq.delete();
        else begin
            if (rpop) m_rxd = rxq.pop_front();
            if (rpsh) rxq.push_back(rx_pdata);
        end
        if (reg_wr && reg_addr == 2'd0) begin
            m_tx_en = reg_wdata[0]; m_tx_trig = int'(reg_wdata[13:8]);
        end
        if (reg_wr && reg_addr == 2'd1) begin
            m_rx_en = reg_wdata[0]; m_rx_trig = int'(reg_wdata[13:8]);
        end
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic clear_in();
        reg_wr = 0; reg_addr = 2'd2; reg_wdata = '0;
        tx_wr = 0; tx_pop = 0; rx_push = 0; rx_rd = 0;
        tx_wdata = '0; rx_pdata = '0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step(); clear_in();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 0;
        m_tx_en = 0; m_rx_en = 0; m_tx_trig = 0; m_rx_trig = 0;
        m_txd = '0; m_rxd = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        compare_all();
        chk("R1", reg_rdata, 32'h2000_0000, "reset status");
        chk("R1", 32'(tx_empty), 32'd1, "reset tx_empty");

        // Disabled queues ignore pushes (R8)
        tx_wr = 1; tx_wdata = 8'h11; rx_push = 1; rx_pdata = 8'h22;
        step(); clear_in(); step();
        chk("R8", reg_rdata, 32'h2000_0000, "disabled push ignored");

        // Enable, triggers tx=4, rx=3; flush bit reads 0 (R2)
        wreg(2'd0, 32'h0000_0403);
        wreg(2'd1, 32'h0000_0301);
        reg_addr = 2'd0; step();
        chk("R2", reg_rdata, 32'h0000_0401, "tx ctrl readback");
        reg_addr = 2'd3; step();
        chk("R2", reg_rdata, 32'h0, "addr 3");
        clear_in();

        // Fill transmit queue past full (R5)
        for (int i = 0; i < 36; i++) begin
            tx_wr = 1; tx_wdata = 8'(8'hA0 + i); step();
        end
        clear_in(); step();
        chk("R5", 32'(tx_ready), 32'd0, "full tx not ready");
        chk("R3", reg_rdata, 32'h0000_2000, "full status");
        // Push with pop on full: push dropped (R5)
        tx_wr = 1; tx_wdata = 8'h55; tx_pop = 1; step(); clear_in(); step();
        chk("R5", reg_rdata[13:8], 32'd31, "full push+pop level");
        // Drain past empty (R9)
        for (int i = 0; i < 34; i++) begin
            tx_pop = 1; step();
        end
        clear_in(); step();
        chk("R9", 32'(tx_data), 32'(8'hA0 + 31), "last byte held");

        // Receive path with threshold (R10, R12)
        for (int i = 0; i < 5; i++) begin
            rx_push = 1; rx_pdata = 8'(8'h30 + i); step();
        end
        rx_push = 1; rx_pdata = 8'h77; rx_rd = 1; step(); clear_in(); step();
        chk("R12", reg_rdata[5:0], 32'd5, "simultaneous push/pop level");
        chk("R10", 32'(irq_rx), 32'd1, "rx irq at 5>=3");
        // Flush with enable (R7)
        rx_push = 1; rx_pdata = 8'h99; reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'h0000_0303;
        step(); clear_in(); step();
        chk("R7", reg_rdata[5:0], 32'd0, "flush empties");
        chk("R7", 32'(irq_rx), 32'd0, "rx irq after flush");
        rx_push = 1; rx_pdata = 8'h44; step(); clear_in();
        rx_rd = 1; step(); clear_in();
        chk("R7", 32'(rx_rdata), 32'h44, "enabled after flush");
        // Fill receive past full (R13)
        for (int i = 0; i < 35; i++) begin
            rx_push = 1; rx_pdata = 8'(i); step();
        end
        clear_in(); step();
        chk("R13", reg_rdata[5:0], 32'd32, "rx level capped");
        // Shutdown: disable and flush (R8)
        wreg(2'd1, 32'h0000_0002);
        rx_push = 1; rx_pdata = 8'hEE; rx_rd = 1; step(); clear_in(); step();
        chk("R8", reg_rdata[5:0], 32'd0, "shutdown discards");
        chk("R8", 32'(irq_rx), 32'd0, "shutdown irq");
        wreg(2'd1, 32'h0000_1001);

        // Mixed traffic
        for (int i = 0; i < 4000; i++) begin
            tx_wr    = ($urandom % 2) == 0;
            tx_wdata = 8'($urandom);
            tx_pop   = ($urandom % 5) < 2;
            rx_push  = ($urandom % 5) < 3;
            rx_pdata = 8'($urandom);
            rx_rd    = ($urandom % 3) == 0;
            reg_addr = 2'($urandom);
            reg_wr   = ($urandom % 40) == 0;
            reg_wdata = {18'd0, 6'($urandom), 6'd0, ($urandom % 8) == 0, ($urandom % 8) != 0};
            if (reg_wr && reg_addr > 2'd1) reg_wr = 0;
            step();
        end
        clear_in(); step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule